// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a programmable watchdog advanced by a 16 Hz tick enable that arrives as a one-cycle pulse on the system clock. Software programs one control byte that holds three things: a five-bit multiplier, a two-bit resolution selecting a power of four, and a top bit that steers what a timeout does. The timeout length is the multiplier times four raised to the resolution, counted in ticks of one sixteenth of a second.

Any access to the control register, whether a write or a read, restarts the countdown and clears the timeout flag. A write loads the new value and a read reloads the stored one, so software services the watchdog simply by reading it. When the count runs out, the timeout flag is set. The block then does one of two things:
- In reset mode it pulses a reset request, clears the control byte and clears the century bit of a small companion register.
- In interrupt mode it pulses an interrupt once and then stays idle until the next control access.

Top module: `wdog_steer`

## Requirements
- R1: The control byte holds the resolution R in bits 1:0, the multiplier M in bits 6:2 and the steering bit in bit 7. After a restart, the timeout fires on the M × 4^R-th tick_i pulse. Clock cycles without tick_i never advance the count.
- R2: A control value with M = 0, including 0x00, disables the watchdog: no number of ticks produces a timeout.
- R3: A write to address 0 (control) stores the byte, restarts the countdown from the new value and clears the timeout flag.
- R4: A read of address 0 returns the stored control byte, restarts the countdown from that stored value and clears the timeout flag.
- R5: A timeout sets the timeout flag. The flag is visible on flag_o and as bit 7 of address 1, whose other bits read 0. It is set in the same cycle as the timeout pulse.
- R6: With bit 7 of control set, a timeout raises rst_req_o for exactly one cycle. Control then reads 0x00 and the century bit reads 0.
- R7: With bit 7 of control clear, a timeout raises irq_o for exactly one cycle and leaves control and the century bit unchanged. No further timeout occurs until the next restart.
- R8: Address 2 stores only bit 6 (the century bit) and reads all other bits as 0. Address 1 ignores writes. Address 3 reads 0x00.
- R9: After reset all outputs are low and addresses 0, 1 and 2 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle 16 Hz count enable |
| acc_i | input | 1 | Register access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | 2 | Register select: 0 control, 1 flags, 2 century, 3 unused |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, valid while acc_i is high |
| rst_req_o | output | 1 | One-cycle reset request on a reset-mode timeout |
| irq_o | output | 1 | One-cycle interrupt on an interrupt-mode timeout |
| flag_o | output | 1 | Timeout flag level |

## Verification
Random control bytes cover the whole multiplier, resolution and steering space, so the measured tick count separates the two shift-and-multiply fields, and the outcome separates the two steering paths. Random bytes with a zero multiplier check that disabling depends on the multiplier field alone. Directed sequences then do three things:
- They restart the countdown midway by a read and by a write with a different value, which shows whether a restart reloads the stored value or the new one.
- They run the longest period, 0x7F.
- They keep ticking after an interrupt-mode timeout, to show the timer stays idle rather than re-arming itself.

// File: rtl/wdog_steer_pkg.sv
`timescale 1ns/1ps
package wdog_steer_pkg;

  // Register select codes, decoded by the register bank
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_FLAG = 2'd1,
    REG_CENT = 2'd2,
    REG_NONE = 2'd3
  } wd_reg_e;

endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int DATA_W   = 1 + MULT_W + RES_W,
  localparam int CENT_BIT = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              expire_i,
  output logic              restart_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [RES_W-1:0]  res_o,
  output logic              steer_o,
  output logic              flag_o
);
  import wdog_steer_pkg::*;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic              cent_q, cent_d;
  wd_reg_e           sel;
  logic              ctrl_wr, ctrl_rd, cent_wr, steer_hit;

  assign sel       = wd_reg_e'(addr_i);
  assign ctrl_wr   = acc_i &  wr_i & (sel == REG_CTRL);
  assign ctrl_rd   = acc_i & ~wr_i & (sel == REG_CTRL);
  assign cent_wr   = acc_i &  wr_i & (sel == REG_CENT);
  assign steer_hit = expire_i & ctrl_q[DATA_W-1];

  // Restart value: the incoming byte on a write, the stored byte on a read
  assign restart_o = ctrl_wr | ctrl_rd;
  assign mult_o    = ctrl_wr ? wdata_i[RES_W +: MULT_W] : ctrl_q[RES_W +: MULT_W];
  assign res_o     = ctrl_wr ? wdata_i[RES_W-1:0]      : ctrl_q[RES_W-1:0];
  assign steer_o   = ctrl_q[DATA_W-1];
  assign flag_o    = flag_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)        ctrl_d = wdata_i;
    else if (steer_hit) ctrl_d = '0;

    flag_d = flag_q;
    if (restart_o)      flag_d = 1'b0;
    else if (expire_i)  flag_d = 1'b1;

    cent_d = cent_q;
    if (cent_wr)        cent_d = wdata_i[CENT_BIT];
    else if (steer_hit) cent_d = 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CTRL: rdata_o = ctrl_q;
      REG_FLAG: rdata_o[DATA_W-1] = flag_q;
      REG_CENT: rdata_o[CENT_BIT] = cent_q;
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cent_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      cent_q <= cent_d;
    end
  end

  // R6: a reset-mode timeout leaves the control byte cleared
  a_r6_ctrl_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_hit && !ctrl_wr) |=> (ctrl_q == '0));
  // R6: the century bit drops on a reset-mode timeout
  a_r6_cent_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_hit && !cent_wr) |=> !cent_q);
  // R5: a timeout raises the flag
  a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !restart_o) |=> flag_q);
  // R3, R4: any control access clears the flag
  a_r3_r4_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !flag_q);
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1),
  localparam int CNT_W     = MULT_W + MAX_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, period;
  logic             run_q, run_d;

  // Multiplier scaled by 4^resolution
  assign period = CNT_W'(mult_i) << (2 * res_i);

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    expire_o = 1'b0;
    if (restart_i) begin
      cnt_d = period;
      run_d = (period != '0);
    end else if (run_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        run_d    = 1'b0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R1: no tick and no restart leaves the count untouched
  a_r1_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
  // R2: a zero multiplier never arms the counter
  a_r2_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && mult_i == '0) |=> !run_q);
  // R7: after a timeout the counter stays idle until a restart
  a_r7_idle_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_q);
endmodule

// File: rtl/wdog_outcome.sv
`timescale 1ns/1ps
module wdog_outcome (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic steer_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic req_d, irq_d;

  always_comb begin
    req_d = expire_i &  steer_i;
    irq_d = expire_i & ~steer_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      rst_req_o <= req_d;
      irq_o     <= irq_d;
    end
  end

  // R6, R7: the two outcomes never coincide
  a_r6_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && irq_o));
  // R7: the interrupt is a single-cycle pulse
  a_r7_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R6: the reset request is a single-cycle pulse
  a_r6_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/wdog_steer.sv
`timescale 1ns/1ps
module wdog_steer #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int DATA_W = 1 + MULT_W + RES_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              flag_o
);
  logic [1:0]        sync_q;
  logic              rst_n;
  logic              expire, restart, steer;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n = sync_q[1];

  wdog_regs #(.MULT_W(MULT_W), .RES_W(RES_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .acc_i(acc_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .expire_i(expire), .restart_o(restart), .mult_o(mult), .res_o(res),
    .steer_o(steer), .flag_o(flag_o)
  );

  wdog_count #(.MULT_W(MULT_W), .RES_W(RES_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick_i), .restart_i(restart),
    .mult_i(mult), .res_i(res), .expire_o(expire)
  );

  wdog_outcome u_outcome (
    .clk_i(clk_i), .rst_ni(rst_n), .expire_i(expire), .steer_i(steer),
    .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  // R5: every outcome pulse is accompanied by the flag
  a_r5_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_req_o || irq_o) |-> flag_o);
endmodule

// File: tb/test_wdog_steer.sv
`timescale 1ns/1ps
module test_wdog_steer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, acc_i = 1'b0, wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       rst_req_o, irq_o, flag_o;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  wdog_steer i_wdog_steer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .acc_i(acc_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .flag_o(flag_o)
  );

  function automatic int exp_period(input logic [7:0] c);
    return int'(c[6:2]) * (1 << (2 * int'(c[1:0])));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    acc_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #2;
    acc_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    acc_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk); #2;
    acc_i = 1'b0;
  endtask

  task automatic step(input bit t);
    tick_i = t;
    @(posedge clk); #2;
    tick_i = 1'b0;
  endtask

  // kind: 0 none, 1 interrupt, 2 reset request
  task automatic run(input int maxt, output int n, output int kind);
    n = 0; kind = 0;
    for (int i = 1; i <= maxt; i++) begin
      step(1'b1);
      if (irq_o || rst_req_o) begin
        n = i;
        kind = rst_req_o ? 2 : 1;
        chk(flag_o, "R5 flag with pulse", flag_o, 1);
        step(1'b0);
        chk(!irq_o && !rst_req_o, "R6/R7 single-cycle pulse", {irq_o, rst_req_o}, 0);
        return;
      end
      step(1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, c;
    int n, kind, p;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R9: reset state
    chk(!rst_req_o && !irq_o && !flag_o, "R9 outputs low", {rst_req_o, irq_o, flag_o}, 0);
    rd(2'd0, d); chk(d == 8'h00, "R9 control", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R9 flags", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R9 century", d, 0);

    // R8: register field behaviour
    wr(2'd2, 8'hFF); rd(2'd2, d); chk(d == 8'h40, "R8 century bit only", d, 8'h40);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk(d == 8'h00, "R8 flags ignore write", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R8 unused address", d, 0);

    // R2: disabled encodings
    wr(2'd0, 8'h03); run(2100, n, kind); chk(kind == 0, "R2 M=0 R=3 disabled", kind, 0);
    wr(2'd0, 8'h80); run(2100, n, kind); chk(kind == 0, "R2 M=0 reset mode disabled", kind, 0);

    // R1: longest period, idle cycles in between do not count
    wr(2'd0, 8'h7F);
    repeat (40) step(1'b0);
    run(2100, n, kind);
    chk(n == 1984 && kind == 1, "R1 longest period", n, 1984);

    // R7: stays idle after an interrupt-mode timeout; control and century kept
    run(300, n, kind); chk(kind == 0, "R7 idle after timeout", kind, 0);
    rd(2'd2, d); chk(d == 8'h40, "R7 century kept", d, 8'h40);
    rd(2'd1, d); chk(d == 8'h80, "R5 flag bit 7", d, 8'h80);

    // R4: a read restarts from the stored value and clears the flag
    rd(2'd0, d); chk(d == 8'h7F, "R7 control kept", d, 8'h7F);
    chk(!flag_o, "R4 read clears flag", flag_o, 0);
    wr(2'd0, 8'h10);
    repeat (3) step(1'b1);
    rd(2'd0, d);
    run(100, n, kind); chk(n == 4 && kind == 1, "R4 read restarts count", n, 4);

    // R3: a write restarts with the new value and clears the flag
    chk(flag_o, "R5 flag set", flag_o, 1);
    wr(2'd0, 8'h0C);
    chk(!flag_o, "R3 write clears flag", flag_o, 0);
    repeat (2) step(1'b1);
    wr(2'd0, 8'h08);
    run(100, n, kind); chk(n == 2 && kind == 1, "R3 write restarts with new value", n, 2);

    // R6: directed reset-mode timeout
    wr(2'd0, 8'h85);
    run(100, n, kind); chk(n == 4 && kind == 2, "R6 reset request", n, 4);
    rd(2'd0, d); chk(d == 8'h00, "R6 control cleared", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R6 century cleared", d, 0);

    // R1, R2, R5, R6, R7: random control bytes
    for (int t = 0; t < 16; t++) begin
      c = 8'($urandom);
      if (t % 5 == 0) c[6:2] = 5'd0;
      p = exp_period(c);
      wr(2'd2, 8'h40);
      wr(2'd0, c);
      run(2100, n, kind);
      if (p == 0) begin
        chk(kind == 0, "R2 random disabled", kind, 0);
      end else begin
        chk(n == p, "R1 random period", n, p);
        chk(kind == (c[7] ? 2 : 1), "R6/R7 random steering", kind, c[7] ? 2 : 1);
        rd(2'd1, d); chk(d == 8'h80, "R5 random flag", d, 8'h80);
        rd(2'd2, d); chk(d == (c[7] ? 8'h00 : 8'h40), "R6/R7 random century", d, c[7] ? 0 : 8'h40);
        rd(2'd0, d); chk(d == (c[7] ? 8'h00 : c), "R6/R7 random control", d, c[7] ? 0 : c);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule